// File: doc/BRIEF.md
# Dead-Block Training Sampler

This block is a tag-only shadow cache that watches a small, evenly spaced subset of the sets of a last-level cache and turns the accesses it sees into training events for a dead-block predictor. It stores no data. Each entry in a sampled row keeps a partial tag, a trace that identifies the last instruction to touch it, a one-bit "predicted dead" flag, a recency position and a valid flag. The associativity of a row is a parameter, and it is set below that of the cache being shadowed, so a block ages out of the sampler sooner than it would out of the cache.

An access request carries the cache set index, the partial tag and the instruction address. If the set is not sampled, the request is accepted and dropped. If the set is sampled, the block runs a fixed four-cycle sequence. It first searches the row. On a hit it sends a reuse (decrement) event for the stored trace. On a miss it picks a victim and, if that victim was valid, sends an eviction (increment) event for the victim's trace. It then asks the predictor about the new trace and writes the entry back with the prediction returned. While the sequence runs, `reqReady` stays low. The predictor tables themselves sit outside this block.

Top module: `deadSampler`

## Requirements
- R1: After reset every entry is invalid, `reqReady` is 1, and `trainValid` and `lookupValid` are 0. The first accesses to any row train nothing until that row is full.
- R2: With stride = CACHE_SETS / SETS (integer division), a cache set s is sampled when s mod stride = 0 and s / stride < SETS. Sampled set s uses sampler row s / stride. `isSampled` shows this for the present `reqSet` as a combinational output.
- R3: A request to a set that is not sampled is accepted and has no effect. `reqReady` stays 1, no training or lookup event occurs, and no row changes.
- R4: A sampled request is accepted at a rising edge where `reqValid` and `reqReady` are both 1. `reqReady` is 0 during the next three cycles, and any change on the request inputs during that time is ignored. `reqReady` is 1 again in the fourth cycle.
- R5: On a hit (a valid entry in the row with an equal tag), `trainValid` is 1 in the second cycle after acceptance, with `trainDec` = 1 and `trainTrace` equal to the trace stored in that entry. At most one entry matches.
- R6: On a miss while the row still has an invalid entry, no training event is sent and the new tag goes into an invalid entry.
- R7: On a miss in a full row, the victim is the least recently used of the entries flagged dead if any entry is flagged dead. Otherwise it is the least recently used entry. In the second cycle, `trainValid` = 1, `trainDec` = 0 and `trainTrace` is the victim's stored trace.
- R8: In the third cycle after acceptance, `lookupValid` = 1 and `lookupTrace` is the XOR of the 16-bit chunks of the accepted address (for 32 bits: pc[15:0] ^ pc[31:16]). The `predDead` input in that cycle becomes the entry's dead flag.
- R9: The entry written becomes most recently used. The other entries in the row keep their relative recency order.
- R10: Every sampled access leaves its tag valid in its row, with the new trace. Tags are never bypassed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request present |
| reqReady | output | 1 | Sampler idle, request can be taken |
| reqSet | input | CSET_W | Cache set index of the access |
| reqTag | input | TAG_W | Partial tag of the access |
| reqPc | input | PC_W | Instruction address of the access |
| isSampled | output | 1 | `reqSet` maps to a sampler row |
| trainValid | output | 1 | Training event this cycle |
| trainDec | output | 1 | 1 = reuse (decrement), 0 = eviction (increment) |
| trainTrace | output | TRACE_W | Trace to train |
| lookupValid | output | 1 | Prediction lookup this cycle |
| lookupTrace | output | TRACE_W | Trace being looked up |
| predDead | input | 1 | Predictor answer for `lookupTrace` |

## Verification
Two pairs of events can fall in the same cycle. A new request can be offered while a sequence is still running. The bench holds `reqValid` high and changes the tag and address during the busy cycles, then checks that `reqReady` stays low and that the lookup trace and all later training use the values latched at acceptance. A miss can also find the least recently used entry and a dead entry in the same row at the same moment. Rows are filled so that the dead entry is not the oldest, and also so that several entries are dead. The evicted trace is then compared with a recency-ordered queue model, which is updated per access and checked against the ports on every clock.

// File: rtl/deadSamplerPkg.sv
package deadSamplerPkg;

  typedef enum logic [1:0] {
    SEQ_IDLE,
    SEQ_SEARCH,
    SEQ_TRAIN,
    SEQ_FILL
  } seqState_t;

  typedef struct packed {
    logic latch;
    logic capture;
    logic train;
    logic fill;
  } seqStrobe_t;

endpackage

// File: rtl/deadSamplerPick.sv
module deadSamplerPick #(
  parameter int WAYS  = 12,
  parameter int TAG_W = 16,
  localparam int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-1:0]             rowValid,
  input  logic [WAYS-1:0]             rowDead,
  input  logic [WAYS-1:0][TAG_W-1:0]  rowTag,
  input  logic [WAYS-1:0][WAY_W-1:0]  rowLru,
  input  logic [TAG_W-1:0]            lookTag,
  output logic [WAYS-1:0]             matchVec,
  output logic                        hit,
  output logic [WAY_W-1:0]            selWay,
  output logic                        needTrain
);

  for (genvar w = 0; w < WAYS; w++) begin : g_way
    assign matchVec[w] = rowValid[w] && (rowTag[w] == lookTag);
  end

  logic             invAny, deadAny;
  logic [WAY_W-1:0] hitWay, invWay, deadWay, deadPos, lruWay;

  always_comb begin
    hit     = 1'b0;
    hitWay  = '0;
    invAny  = 1'b0;
    invWay  = '0;
    deadAny = 1'b0;
    deadWay = '0;
    deadPos = '0;
    lruWay  = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (matchVec[w] && !hit) begin
        hit    = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (!rowValid[w] && !invAny) begin
        invAny = 1'b1;
        invWay = WAY_W'(w);
      end
      if (rowValid[w] && rowDead[w] && (!deadAny || rowLru[w] > deadPos)) begin
        deadAny = 1'b1;
        deadWay = WAY_W'(w);
        deadPos = rowLru[w];
      end
      if (rowLru[w] == WAY_W'(WAYS - 1)) begin
        lruWay = WAY_W'(w);
      end
    end
  end

  always_comb begin
    if (hit)          selWay = hitWay;
    else if (invAny)  selWay = invWay;
    else if (deadAny) selWay = deadWay;
    else              selWay = lruWay;
    needTrain = hit || !invAny;
  end

endmodule

// File: rtl/deadSamplerCtrl.sv
module deadSamplerCtrl
  import deadSamplerPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  input  logic       setSampled,
  output logic       reqReady,
  output seqStrobe_t strobe
);

  seqState_t state, nextState;

  always_comb begin
    nextState = state;
    unique case (state)
      SEQ_IDLE:   if (reqValid && setSampled) nextState = SEQ_SEARCH;
      SEQ_SEARCH: nextState = SEQ_TRAIN;
      SEQ_TRAIN:  nextState = SEQ_FILL;
      SEQ_FILL:   nextState = SEQ_IDLE;
      default:    nextState = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= SEQ_IDLE;
    else       state <= nextState;
  end

  assign reqReady = (state == SEQ_IDLE);

  always_comb begin
    strobe.latch   = (state == SEQ_IDLE) && reqValid && setSampled;
    strobe.capture = (state == SEQ_SEARCH);
    strobe.train   = (state == SEQ_TRAIN);
    strobe.fill    = (state == SEQ_FILL);
  end

  p_busy_after_accept_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.latch |=> !reqReady);

  p_ready_after_fill_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> reqReady);

endmodule

// File: rtl/deadSamplerData.sv
module deadSamplerData
  import deadSamplerPkg::*;
#(
  parameter int CACHE_SETS = 1024,
  parameter int SETS       = 55,
  parameter int WAYS       = 12,
  parameter int TAG_W      = 16,
  parameter int TRACE_W    = 16,
  parameter int PC_W       = 32,
  localparam int CSET_W    = $clog2(CACHE_SETS),
  localparam int SIDX_W    = $clog2(SETS),
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  seqStrobe_t         strobe,
  input  logic [CSET_W-1:0]  reqSet,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic [PC_W-1:0]    reqPc,
  input  logic               predDead,
  output logic               setSampled,
  output logic               trainValid,
  output logic               trainDec,
  output logic [TRACE_W-1:0] trainTrace,
  output logic               lookupValid,
  output logic [TRACE_W-1:0] lookupTrace
);

  localparam logic [31:0] STRIDE = 32'(CACHE_SETS / SETS);

  // Row storage
  logic [WAYS-1:0]               vldMem   [SETS];
  logic [WAYS-1:0]               deadMem  [SETS];
  logic [WAYS-1:0][TAG_W-1:0]    tagMem   [SETS];
  logic [WAYS-1:0][TRACE_W-1:0]  traceMem [SETS];
  logic [WAYS-1:0][WAY_W-1:0]    lruMem   [SETS];

  // Latched request and search result
  logic [SIDX_W-1:0]  rowQ;
  logic [TAG_W-1:0]   tagQ;
  logic [TRACE_W-1:0] traceQ;
  logic               hitQ;
  logic [WAY_W-1:0]   wayQ;
  logic               trainEnQ;
  logic [TRACE_W-1:0] evictTraceQ;

  // Set mapping
  logic [31:0] setNum;
  assign setNum     = 32'(reqSet);
  assign setSampled = ((setNum % STRIDE) == 32'd0) && ((setNum / STRIDE) < 32'(SETS));

  // Trace: XOR fold of the instruction address into TRACE_W bits
  logic [TRACE_W-1:0] foldTrace;
  always_comb begin
    foldTrace = '0;
    for (int i = 0; i < PC_W; i++) begin
      foldTrace[i % TRACE_W] = foldTrace[i % TRACE_W] ^ reqPc[i];
    end
  end

  // Victim / hit selection on the latched row
  logic [WAYS-1:0]  matchVec;
  logic             hit;
  logic [WAY_W-1:0] selWay;
  logic             needTrain;

  deadSamplerPick #(
    .WAYS  (WAYS),
    .TAG_W (TAG_W)
  ) uPick (
    .rowValid  (vldMem[rowQ]),
    .rowDead   (deadMem[rowQ]),
    .rowTag    (tagMem[rowQ]),
    .rowLru    (lruMem[rowQ]),
    .lookTag   (tagQ),
    .matchVec  (matchVec),
    .hit       (hit),
    .selWay    (selWay),
    .needTrain (needTrain)
  );

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        vldMem[s]   <= '0;
        deadMem[s]  <= '0;
        tagMem[s]   <= '0;
        traceMem[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          lruMem[s][w] <= WAY_W'(w);
        end
      end
      rowQ        <= '0;
      tagQ        <= '0;
      traceQ      <= '0;
      hitQ        <= 1'b0;
      wayQ        <= '0;
      trainEnQ    <= 1'b0;
      evictTraceQ <= '0;
    end else begin
      if (strobe.latch) begin
        rowQ   <= SIDX_W'(setNum / STRIDE);
        tagQ   <= reqTag;
        traceQ <= foldTrace;
      end
      if (strobe.capture) begin
        hitQ        <= hit;
        wayQ        <= selWay;
        trainEnQ    <= needTrain;
        evictTraceQ <= traceMem[rowQ][selWay];
      end
      if (strobe.fill) begin
        vldMem[rowQ][wayQ]   <= 1'b1;
        deadMem[rowQ][wayQ]  <= predDead;
        tagMem[rowQ][wayQ]   <= tagQ;
        traceMem[rowQ][wayQ] <= traceQ;
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == wayQ) begin
            lruMem[rowQ][w] <= '0;
          end else if (lruMem[rowQ][w] < lruMem[rowQ][wayQ]) begin
            lruMem[rowQ][w] <= lruMem[rowQ][w] + 1'b1;
          end
        end
      end
    end
  end

  assign trainValid  = strobe.train && trainEnQ;
  assign trainDec    = hitQ;
  assign trainTrace  = evictTraceQ;
  assign lookupValid = strobe.fill;
  assign lookupTrace = traceQ;

  // Checks next to the storage they guard
  logic [WAYS-1:0] lruMask;
  always_comb begin
    lruMask = '0;
    for (int w = 0; w < WAYS; w++) begin
      lruMask[lruMem[rowQ][w]] = 1'b1;
    end
  end

  p_lru_perm_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> ($countones(lruMask) == WAYS));

  p_one_match_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.capture |-> $onehot0(matchVec));

  p_dead_victim_r7: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.capture && !hit && needTrain && (|(vldMem[rowQ] & deadMem[rowQ])))
      |-> deadMem[rowQ][selWay]);

  p_fill_valid_r10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.fill |=> vldMem[rowQ][wayQ]);

endmodule

// File: rtl/deadSampler.sv
module deadSampler
  import deadSamplerPkg::*;
#(
  parameter int CACHE_SETS = 1024,
  parameter int SETS       = 55,
  parameter int WAYS       = 12,
  parameter int TAG_W      = 16,
  parameter int TRACE_W    = 16,
  parameter int PC_W       = 32,
  localparam int CSET_W    = $clog2(CACHE_SETS)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               reqValid,
  output logic               reqReady,
  input  logic [CSET_W-1:0]  reqSet,
  input  logic [TAG_W-1:0]   reqTag,
  input  logic [PC_W-1:0]    reqPc,
  output logic               isSampled,
  output logic               trainValid,
  output logic               trainDec,
  output logic [TRACE_W-1:0] trainTrace,
  output logic               lookupValid,
  output logic [TRACE_W-1:0] lookupTrace,
  input  logic               predDead
);

  seqStrobe_t strobe;

  deadSamplerCtrl uCtrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .setSampled (isSampled),
    .reqReady   (reqReady),
    .strobe     (strobe)
  );

  deadSamplerData #(
    .CACHE_SETS (CACHE_SETS),
    .SETS       (SETS),
    .WAYS       (WAYS),
    .TAG_W      (TAG_W),
    .TRACE_W    (TRACE_W),
    .PC_W       (PC_W)
  ) uData (
    .clk         (clk),
    .rstN        (rstN),
    .strobe      (strobe),
    .reqSet      (reqSet),
    .reqTag      (reqTag),
    .reqPc       (reqPc),
    .predDead    (predDead),
    .setSampled  (isSampled),
    .trainValid  (trainValid),
    .trainDec    (trainDec),
    .trainTrace  (trainTrace),
    .lookupValid (lookupValid),
    .lookupTrace (lookupTrace)
  );

endmodule

// File: tb/deadSampler_test.sv
module deadSampler_test;

  localparam int CLK_PERIOD = 10;
  localparam int CS  = 64;
  localparam int NS  = 5;
  localparam int NW  = 4;
  localparam int ST  = CS / NS;
  localparam int CW  = $clog2(CS);

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [CW-1:0] reqSet = '0;
  logic [15:0] reqTag = '0;
  logic [31:0] reqPc = '0;
  logic        isSampled;
  logic        trainValid, trainDec, lookupValid;
  logic [15:0] trainTrace, lookupTrace;
  logic        predDead = 1'b0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  deadSampler #(
    .CACHE_SETS (CS), .SETS (NS), .WAYS (NW),
    .TAG_W (16), .TRACE_W (16), .PC_W (32)
  ) uut (
    .clk (clk), .rstN (rstN), .reqValid (reqValid), .reqReady (reqReady),
    .reqSet (reqSet), .reqTag (reqTag), .reqPc (reqPc), .isSampled (isSampled),
    .trainValid (trainValid), .trainDec (trainDec), .trainTrace (trainTrace),
    .lookupValid (lookupValid), .lookupTrace (lookupTrace), .predDead (predDead)
  );

  // Behavioural model: each row is a queue ordered most recent first
  typedef struct { int tag; int trace; bit dead; } mEnt_t;
  mEnt_t rows [NS][$];

  int    checks = 0;
  int    errors = 0;
  string curReq = "R1";
  bit    cmpOn = 1'b0;
  bit    eReady = 1'b1, eSamp = 1'b1, eTv = 1'b0, eTd = 1'b0, eLv = 1'b0;
  int    eTt = 0, eLt = 0;

  task automatic chk(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", curReq, what, act, exp);
    end
  endtask

  function automatic int traceOf(logic [31:0] pc);
    return int'(pc[15:0] ^ pc[31:16]);
  endfunction

  always @(posedge clk) begin
    if (cmpOn) begin
      #1;
      chk("reqReady", reqReady, eReady);
      chk("isSampled", isSampled, eSamp);
      chk("trainValid", trainValid, eTv);
      if (eTv) begin
        chk("trainDec", trainDec, eTd);
        chk("trainTrace", trainTrace, eTt);
      end
      chk("lookupValid", lookupValid, eLv);
      if (eLv) chk("lookupTrace", lookupTrace, eLt);
    end
  end

  task automatic access(int setI, int tagI, logic [31:0] pc, bit pred, string rq);
    bit samp;
    int r, hitIdx, vic;
    bit doTrain, isDec;
    int tTrace;
    mEnt_t ne;
    samp = (setI % ST == 0) && (setI / ST < NS);
    r = setI / ST;
    doTrain = 1'b0; isDec = 1'b0; tTrace = 0;
    if (samp) begin
      hitIdx = -1;
      foreach (rows[r][i]) if (rows[r][i].tag == tagI) hitIdx = i;
      ne.tag = tagI; ne.trace = traceOf(pc); ne.dead = pred;
      if (hitIdx >= 0) begin
        doTrain = 1'b1; isDec = 1'b1; tTrace = rows[r][hitIdx].trace;
        rows[r].delete(hitIdx);
      end else if (rows[r].size() == NW) begin
        vic = NW - 1;
        for (int i = NW - 1; i >= 0; i--) begin
          if (rows[r][i].dead) begin vic = i; break; end
        end
        doTrain = 1'b1; tTrace = rows[r][vic].trace;
        rows[r].delete(vic);
      end
      rows[r].push_front(ne);
    end
    @(negedge clk);
    curReq = rq;
    reqValid = 1'b1; reqSet = CW'(setI); reqTag = 16'(tagI); reqPc = pc; predDead = pred;
    eReady = !samp; eSamp = samp; eTv = 1'b0; eLv = 1'b0;
    if (!samp) begin
      @(negedge clk);
      reqValid = 1'b0;
      return;
    end
    @(negedge clk);
    // held request with changed fields while busy: must be ignored (R4)
    reqTag = reqTag ^ 16'h5a5a; reqPc = ~pc;
    eReady = 1'b0; eTv = doTrain; eTd = isDec; eTt = tTrace;
    @(negedge clk);
    eTv = 1'b0; eLv = 1'b1; eLt = traceOf(pc);
    @(negedge clk);
    reqValid = 1'b0; eLv = 1'b0; eReady = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL R4 watchdog: actual hung expected finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1: idle outputs after reset
    chk("reqReady", reqReady, 1);
    chk("trainValid", trainValid, 0);
    chk("lookupValid", lookupValid, 0);
    cmpOn = 1'b1;

    // R6 / R1: fill row 0 from empty, no training expected
    access(0, 'h1111, 32'h0040_1000, 1'b0, "R6");
    access(0, 'h2222, 32'h0040_2004, 1'b0, "R6");
    access(0, 'h3333, 32'h0040_3008, 1'b1, "R6");
    access(0, 'h4444, 32'h0040_400c, 1'b0, "R6");
    // R5 / R8: hit on the oldest entry, lookup of new trace
    access(0, 'h1111, 32'h1234_8888, 1'b0, "R5");
    // R7: dead entry 0x3333 is evicted ahead of LRU 0x2222
    access(0, 'h5555, 32'h0050_0010, 1'b0, "R7");
    // R7: no dead entry left, plain LRU (0x2222)
    access(0, 'h6666, 32'h0060_0014, 1'b0, "R7");
    // R2 / R3: unsampled sets, including one past the last row
    access(17, 'h7777, 32'h0070_0000, 1'b0, "R3");
    access(60, 'h7777, 32'h0070_0004, 1'b0, "R2");
    access(13, 'h1111, 32'h0070_0008, 1'b0, "R3");
    // R10: rows are independent; same tag misses in row 1
    access(12, 'h1111, 32'h0080_0000, 1'b0, "R10");
    access(12, 'h1111, 32'h0080_0100, 1'b0, "R10");
    // R7: several dead entries, the oldest dead goes first
    access(24, 'hA001, 32'h0090_0001, 1'b1, "R7");
    access(24, 'hA002, 32'h0090_0002, 1'b1, "R7");
    access(24, 'hA003, 32'h0090_0003, 1'b1, "R7");
    access(24, 'hA004, 32'h0090_0004, 1'b1, "R7");
    access(24, 'hA005, 32'h0090_0005, 1'b0, "R7");
    access(24, 'hA006, 32'h0090_0006, 1'b0, "R7");
    // R9: hits reorder recency, LRU victim follows
    access(36, 'hB001, 32'h00a0_0001, 1'b0, "R9");
    access(36, 'hB002, 32'h00a0_0002, 1'b0, "R9");
    access(36, 'hB003, 32'h00a0_0003, 1'b0, "R9");
    access(36, 'hB004, 32'h00a0_0004, 1'b0, "R9");
    access(36, 'hB002, 32'h00a0_0012, 1'b0, "R9");
    access(36, 'hB001, 32'h00a0_0011, 1'b0, "R9");
    access(36, 'hB005, 32'h00a0_0005, 1'b0, "R9");
    access(36, 'hB004, 32'h00a0_0014, 1'b0, "R9");
    // R8: dead flag taken from predDead at lookup, seen on later eviction
    access(48, 'hC001, 32'h00b0_0001, 1'b0, "R8");
    access(48, 'hC002, 32'h00b0_0002, 1'b0, "R8");
    access(48, 'hC003, 32'h00b0_0003, 1'b1, "R8");
    access(48, 'hC004, 32'h00b0_0004, 1'b0, "R8");
    access(48, 'hC005, 32'h00b0_0005, 1'b0, "R8");
    // R10: evicted tag comes back and allocates again
    access(0, 'h3333, 32'h0040_3008, 1'b0, "R10");
    access(0, 'h3333, 32'h0041_3008, 1'b0, "R10");
    repeat (3) @(negedge clk);
    cmpOn = 1'b0;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule